// File: doc/BRIEF.md
# Output Command-versus-Proof Monitor

This block supervises a single digital output channel. It sits between the command that asks for the output to be on or off and the switch driver. It gates the drive enable through an overcurrent and overtemperature protection policy. It also checks the observed proof flags against the drive the channel is actually applying.

Two proof flags arrive from sensing logic outside the block. One says that load current is above threshold. The other says that voltage is present on the output node. Only the current flag counts as proof that a load is connected. A disagreement between the applied drive and the proof is ignored while a programmable settle window runs after every drive change. Once the window ends, the disagreement must persist for a programmable number of ticks before a mismatch event is raised. Each mismatch event carries a reason code.

Overcurrent trips remove the drive, wait a programmable number of ticks and then retry. The retries are limited by a budget, and once it is spent the channel locks out until an explicit clear. Trips, overtemperature events and mismatches each have their own event code and their own counter. No mismatch ever causes a retry.

Top module: `do_proof_monitor`

## Requirements
- R1: `drive_en` equals `cmd_on` while protection is in the run state and `otp_flag` is low, and is 0 otherwise. `obs_on` is `prf_cur` OR `prf_volt`.
- R2: With the drive on and `prf_cur` low, the channel is in disagreement with reason code 1 (no load / no actuation). This holds even when `prf_volt` is high.
- R3: With the drive off and either `prf_cur` or `prf_volt` high, the channel is in disagreement with reason code 2 (stuck / backfed).
- R4: Every change of `drive_en` restarts a settle window. During the window, the first `cfg_settle` ticks are ignored. After the window, a mismatch event (event code 1) is raised on the tick that completes `cfg_persist` consecutive disagreeing ticks, where 0 counts as 1. A tick without disagreement restarts the count. Only one event is raised per unbroken episode, and each event adds one to `mis_cnt`.
- R5: `ocp_flag` high while `drive_en` is high is a trip. A trip adds one to `ocp_cnt` and removes the drive from the next cycle. If the trips since the last clear are fewer than `cfg_retry_max`, the trip raises event code 2 and the drive returns on the max(`cfg_retry_gap`,1)-th tick.
- R6: A trip that finds `cfg_retry_max` trips already used raises event code 3 and sets `locked`. The drive stays off until `lock_clr`. `lock_clr` also empties the retry budget, and it takes precedence over a trip in the same cycle.
- R7: A rising edge of `otp_flag` adds one to `otp_cnt` and raises event code 4. The level of `otp_flag` forces the drive off but is counted only once. `mis_cnt` is not touched by it.
- R8: After reset, all outputs and counters are zero. `mis_reason` keeps the reason of the latest mismatch until the next one. Counters never decrease and saturate at all ones.
- R9: `evt_valid` and `evt_code` are valid in the cycle after the clock edge that saw the cause. When causes coincide, the code shown follows the priority lockout/trip over overtemperature over mismatch, and every counter still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| cmd_on | input | 1 | Commanded output state |
| prf_cur | input | 1 | Load current above threshold |
| prf_volt | input | 1 | Voltage present on output node |
| ocp_flag | input | 1 | Overcurrent indication |
| otp_flag | input | 1 | Overtemperature indication |
| lock_clr | input | 1 | Clears lockout and retry budget |
| cfg_settle | input | SET_W | Blanking ticks after a drive change |
| cfg_persist | input | PER_W | Consecutive disagreeing ticks to declare a mismatch |
| cfg_retry_max | input | RET_W | Retries allowed before lockout |
| cfg_retry_gap | input | GAP_W | Ticks between a trip and its retry |
| drive_en | output | 1 | Gated drive enable |
| obs_on | output | 1 | Observed output state |
| locked | output | 1 | Lockout active |
| evt_valid | output | 1 | Event pulse |
| evt_code | output | 3 | 1 mismatch, 2 trip, 3 lockout, 4 overtemperature |
| mis_reason | output | 2 | Reason of latest mismatch (1 no load, 2 stuck) |
| mis_cnt | output | CNT_W | Mismatch count |
| ocp_cnt | output | CNT_W | Overcurrent trip count |
| otp_cnt | output | CNT_W | Overtemperature event count |

## Verification
The monitor is driven with several proof patterns. Full proof with the drive on shows that agreement raises nothing. Voltage-only proof with the drive on shows that a moved node is not taken as a present load. Current or voltage alone with the drive off both show up as the stuck reason. Late proof inside the settle window and one- and two-tick dropouts separate blanking and persistence from real faults. Repeated overcurrent pulses walk the retry budget into lockout and back out through the clear. An overtemperature edge that lands on the same tick as a mismatch declaration checks the event priority and shows that both counters still count.

// File: rtl/do_mon_pkg.sv
// Shared types for the output command-versus-proof monitor.
package do_mon_pkg;
    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_MISMATCH = 3'd1,
        EV_OCP_TRIP = 3'd2,
        EV_LOCKOUT  = 3'd3,
        EV_OTP_TRIP = 3'd4
    } evt_code_t;

    typedef enum logic [1:0] {
        RS_NONE    = 2'd0,
        RS_NO_LOAD = 2'd1,
        RS_STUCK   = 2'd2
    } mis_reason_t;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_BACKOFF = 2'd1,
        PS_LOCKED  = 2'd2
    } prot_state_t;

    localparam int NUM_CNT = 3;
    localparam int CNT_MIS = 0;
    localparam int CNT_OCP = 1;
    localparam int CNT_OTP = 2;
endpackage

// File: rtl/do_trip_ctrl.sv
// Protection policy: gates the drive, handles overcurrent trips with a
// bounded retry budget and lockout, and detects overtemperature edges.
// Assumes tick is a single-cycle pulse and flags are already synchronous.
module do_trip_ctrl
    import do_mon_pkg::*;
#(
    parameter int RET_W = 4,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_on,
    input  logic             ocp_flag,
    input  logic             otp_flag,
    input  logic             lock_clr,
    input  logic [RET_W-1:0] cfg_retry_max,
    input  logic [GAP_W-1:0] cfg_retry_gap,
    output logic             drive_en,
    output logic             ocp_trip,
    output logic             lock_trip,
    output logic             otp_rise,
    output logic             locked
);
    prot_state_t      st;
    logic [RET_W-1:0] trips;
    logic [GAP_W-1:0] gap;
    logic             otp_q;
    logic             trip_now;

    assign drive_en  = cmd_on && (st == PS_RUN) && !otp_flag;
    assign trip_now  = drive_en && ocp_flag && !lock_clr;
    assign lock_trip = trip_now && (trips >= cfg_retry_max);
    assign ocp_trip  = trip_now && !lock_trip;
    assign otp_rise  = otp_flag && !otp_q;
    assign locked    = (st == PS_LOCKED);

    // Protection state, retry budget and backoff countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= PS_RUN;
            trips <= '0;
            gap   <= '0;
            otp_q <= 1'b0;
        end else begin
            otp_q <= otp_flag;
            if (lock_clr) begin
                st    <= PS_RUN;
                trips <= '0;
                gap   <= '0;
            end else begin
                case (st)
                    PS_RUN: begin
                        if (lock_trip) begin
                            st <= PS_LOCKED;
                        end else if (ocp_trip) begin
                            st    <= PS_BACKOFF;
                            trips <= trips + 1'b1;
                            gap   <= cfg_retry_gap;
                        end
                    end
                    PS_BACKOFF: begin
                        if (tick) begin
                            if (gap <= GAP_W'(1)) st  <= PS_RUN;
                            else                  gap <= gap - 1'b1;
                        end
                    end
                    PS_LOCKED: ;
                    default: st <= PS_RUN;
                endcase
            end
        end
    end

    // A backoff always follows at least one counted trip.
    assert_retry_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_BACKOFF) |-> (trips != '0));

    // Lockout persists until explicitly cleared.
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !lock_clr) |=> locked);
endmodule

// File: rtl/do_proof_cmp.sv
// Compares applied drive with proof flags. Blanks after each drive change,
// then requires a run of disagreeing ticks before firing one mismatch.
// Assumes tick is a single-cycle pulse; cfg_persist of 0 acts as 1.
module do_proof_cmp
    import do_mon_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             drv,
    input  logic             prf_cur,
    input  logic             prf_volt,
    input  logic [SET_W-1:0] cfg_settle,
    input  logic [PER_W-1:0] cfg_persist,
    output logic             mis_fire,
    output mis_reason_t      mis_reason
);
    logic             drv_q;
    logic [SET_W-1:0] settle_cnt;
    logic [PER_W-1:0] pcnt;
    logic             reported;
    logic             dis_nl, dis_st, dis, changed, active;
    logic [PER_W:0]   per_lim, pcnt_nx;

    assign dis_nl     = drv && !prf_cur;
    assign dis_st     = !drv && (prf_cur || prf_volt);
    assign dis        = dis_nl || dis_st;
    assign changed    = (drv != drv_q);
    assign active     = tick && !changed && (settle_cnt == '0);
    assign per_lim    = (cfg_persist == '0) ? (PER_W+1)'(1) : {1'b0, cfg_persist};
    assign pcnt_nx    = {1'b0, pcnt} + 1'b1;
    assign mis_fire   = active && dis && !reported && (pcnt_nx >= per_lim);
    assign mis_reason = dis_nl ? RS_NO_LOAD : RS_STUCK;

    // Blanking window, persistence run and per-episode report flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q      <= 1'b0;
            settle_cnt <= '0;
            pcnt       <= '0;
            reported   <= 1'b0;
        end else begin
            drv_q <= drv;
            if (changed) begin
                settle_cnt <= cfg_settle;
                pcnt       <= '0;
                reported   <= 1'b0;
            end else if (tick) begin
                if (settle_cnt != '0) begin
                    settle_cnt <= settle_cnt - 1'b1;
                end else if (dis) begin
                    if (!reported) begin
                        if (mis_fire) begin
                            pcnt     <= '0;
                            reported <= 1'b1;
                        end else begin
                            pcnt <= pcnt_nx[PER_W-1:0];
                        end
                    end
                end else begin
                    pcnt     <= '0;
                    reported <= 1'b0;
                end
            end
        end
    end

    // One declaration per episode: never on two consecutive cycles.
    assert_one_per_episode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mis_fire |=> !mis_fire);
endmodule

// File: rtl/do_sat_cnt.sv
// Saturating event counter; increments by one per inc pulse.
module do_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count up, hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
    end

    assert_cnt_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt >= $past(cnt));
endmodule

// File: rtl/do_evt_stat.sv
// Encodes one prioritised event code per cycle, holds the latest mismatch
// reason and keeps the three per-channel counters.
module do_evt_stat
    import do_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ocp_trip,
    input  logic             lock_trip,
    input  logic             otp_rise,
    input  logic             mis_fire,
    input  mis_reason_t      mis_reason_i,
    output logic             evt_valid,
    output evt_code_t        evt_code,
    output mis_reason_t      reason_q,
    output logic [CNT_W-1:0] mis_cnt,
    output logic [CNT_W-1:0] ocp_cnt,
    output logic [CNT_W-1:0] otp_cnt
);
    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

    assign inc[CNT_MIS] = mis_fire;
    assign inc[CNT_OCP] = ocp_trip || lock_trip;
    assign inc[CNT_OTP] = otp_rise;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        do_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc[i]), .cnt(cnt_arr[i])
        );
    end

    assign mis_cnt = cnt_arr[CNT_MIS];
    assign ocp_cnt = cnt_arr[CNT_OCP];
    assign otp_cnt = cnt_arr[CNT_OTP];

    // Register the highest-priority event of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= EV_NONE;
        end else begin
            evt_valid <= |inc;
            if (lock_trip)     evt_code <= EV_LOCKOUT;
            else if (ocp_trip) evt_code <= EV_OCP_TRIP;
            else if (otp_rise) evt_code <= EV_OTP_TRIP;
            else if (mis_fire) evt_code <= EV_MISMATCH;
            else               evt_code <= EV_NONE;
        end
    end

    // Hold the reason of the latest mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)        reason_q <= RS_NONE;
        else if (mis_fire) reason_q <= mis_reason_i;
    end

    assert_code_matches_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid == (evt_code != EV_NONE));
endmodule

// File: rtl/do_proof_monitor.sv
// Top of the output command-versus-proof monitor. Connects the protection
// policy, the proof comparator and the event/statistics block.
// Assumes all inputs are synchronous to clk and tick is a one-cycle pulse.
module do_proof_monitor
    import do_mon_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int PER_W = 8,
    parameter int RET_W = 4,
    parameter int GAP_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_on,
    input  logic             prf_cur,
    input  logic             prf_volt,
    input  logic             ocp_flag,
    input  logic             otp_flag,
    input  logic             lock_clr,
    input  logic [SET_W-1:0] cfg_settle,
    input  logic [PER_W-1:0] cfg_persist,
    input  logic [RET_W-1:0] cfg_retry_max,
    input  logic [GAP_W-1:0] cfg_retry_gap,
    output logic             drive_en,
    output logic             obs_on,
    output logic             locked,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic [1:0]       mis_reason,
    output logic [CNT_W-1:0] mis_cnt,
    output logic [CNT_W-1:0] ocp_cnt,
    output logic [CNT_W-1:0] otp_cnt
);
    logic        ocp_trip, lock_trip, otp_rise, mis_fire;
    mis_reason_t mis_rs, reason_q;
    evt_code_t   code_q;

    do_trip_ctrl #(.RET_W(RET_W), .GAP_W(GAP_W)) u_trip (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_on(cmd_on),
        .ocp_flag(ocp_flag), .otp_flag(otp_flag), .lock_clr(lock_clr),
        .cfg_retry_max(cfg_retry_max), .cfg_retry_gap(cfg_retry_gap),
        .drive_en(drive_en), .ocp_trip(ocp_trip), .lock_trip(lock_trip),
        .otp_rise(otp_rise), .locked(locked)
    );

    do_proof_cmp #(.SET_W(SET_W), .PER_W(PER_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .drv(drive_en),
        .prf_cur(prf_cur), .prf_volt(prf_volt),
        .cfg_settle(cfg_settle), .cfg_persist(cfg_persist),
        .mis_fire(mis_fire), .mis_reason(mis_rs)
    );

    do_evt_stat #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .ocp_trip(ocp_trip), .lock_trip(lock_trip),
        .otp_rise(otp_rise), .mis_fire(mis_fire), .mis_reason_i(mis_rs),
        .evt_valid(evt_valid), .evt_code(code_q), .reason_q(reason_q),
        .mis_cnt(mis_cnt), .ocp_cnt(ocp_cnt), .otp_cnt(otp_cnt)
    );

    assign obs_on     = prf_cur || prf_volt;
    assign evt_code   = code_q;
    assign mis_reason = reason_q;

    assert_lock_blocks_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !drive_en);

    assert_mis_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd1) |-> $past(tick));

    assert_trip_drops_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == 3'd2 || evt_code == 3'd3)) |-> !drive_en);
endmodule

// File: tb/tb_do_proof_monitor.sv
module tb_do_proof_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, cmd_on = 0, prf_cur = 0, prf_volt = 0;
    logic ocp_flag = 0, otp_flag = 0, lock_clr = 0;
    logic [7:0] cfg_settle = 8'd2, cfg_persist = 8'd3, cfg_retry_gap = 8'd2;
    logic [3:0] cfg_retry_max = 4'd2;
    logic drive_en, obs_on, locked, evt_valid;
    logic [2:0] evt_code;
    logic [1:0] mis_reason;
    logic [7:0] mis_cnt, ocp_cnt, otp_cnt;

    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    do_proof_monitor dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_on(cmd_on),
        .prf_cur(prf_cur), .prf_volt(prf_volt), .ocp_flag(ocp_flag),
        .otp_flag(otp_flag), .lock_clr(lock_clr), .cfg_settle(cfg_settle),
        .cfg_persist(cfg_persist), .cfg_retry_max(cfg_retry_max),
        .cfg_retry_gap(cfg_retry_gap), .drive_en(drive_en), .obs_on(obs_on),
        .locked(locked), .evt_valid(evt_valid), .evt_code(evt_code),
        .mis_reason(mis_reason), .mis_cnt(mis_cnt), .ocp_cnt(ocp_cnt),
        .otp_cnt(otp_cnt)
    );

    // Behavioural reference model state.
    int m_st, m_trips, m_gap, m_settle, m_pc, m_mis, m_ocp, m_otp, m_reason, m_evc;
    bit m_otp_q, m_drv_q, m_rep;

    function automatic bit model_drive();
        return cmd_on && (m_st == 0) && !otp_flag;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_trips = 0; m_gap = 0; m_settle = 0; m_pc = 0;
            m_mis = 0; m_ocp = 0; m_otp = 0; m_reason = 0; m_evc = 0;
            m_otp_q = 0; m_drv_q = 0; m_rep = 0;
        end else begin
            bit drv, nl, stk, trip;
            int ev, lim;
            drv = model_drive();
            nl = drv && !prf_cur;
            stk = !drv && (prf_cur || prf_volt);
            ev = 0;
            trip = drv && ocp_flag && !lock_clr;
            if (trip && m_ocp < 255) m_ocp++;
            if (lock_clr) begin
                m_st = 0; m_trips = 0; m_gap = 0;
            end else if (trip) begin
                if (m_trips >= int'(cfg_retry_max)) begin m_st = 2; ev = 3; end
                else begin m_st = 1; m_trips++; m_gap = int'(cfg_retry_gap); ev = 2; end
            end else if (m_st == 1 && tick) begin
                if (m_gap <= 1) m_st = 0; else m_gap--;
            end
            if (otp_flag && !m_otp_q) begin
                if (m_otp < 255) m_otp++;
                if (ev == 0) ev = 4;
            end
            m_otp_q = otp_flag;
            lim = (cfg_persist == 0) ? 1 : int'(cfg_persist);
            if (drv != m_drv_q) begin
                m_settle = int'(cfg_settle); m_pc = 0; m_rep = 0;
            end else if (tick) begin
                if (m_settle > 0) m_settle--;
                else if (nl || stk) begin
                    if (!m_rep) begin
                        m_pc++;
                        if (m_pc >= lim) begin
                            if (m_mis < 255) m_mis++;
                            m_reason = nl ? 1 : 2;
                            m_rep = 1; m_pc = 0;
                            if (ev == 0) ev = 1;
                        end
                    end
                end else begin
                    m_pc = 0; m_rep = 0;
                end
            end
            m_drv_q = drv;
            m_evc = ev;
        end
    end

    task automatic cmp(string tag, string name, int act, int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            n_tests++;
            cmp("R1", "drive_en", int'(drive_en), int'(model_drive()));
            cmp("R1", "obs_on", int'(obs_on), int'(prf_cur || prf_volt));
            cmp("R6", "locked", int'(locked), int'(m_st == 2));
            cmp("R9", "evt_valid", int'(evt_valid), int'(m_evc != 0));
            cmp("R9", "evt_code", int'(evt_code), m_evc);
            cmp("R8", "mis_reason", int'(mis_reason), m_reason);
            cmp("R4", "mis_cnt", int'(mis_cnt), m_mis);
            cmp("R5", "ocp_cnt", int'(ocp_cnt), m_ocp);
            cmp("R7", "otp_cnt", int'(otp_cnt), m_otp);
        end
    end

    task automatic chk(string tag, string name, int act, int exp);
        n_tests++;
        cmp(tag, name, act, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tk(int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    // One overcurrent pulse; checks the event in the following cycle.
    task automatic trip_pulse(int exp_code, string tag);
        @(negedge clk) ocp_flag = 1'b1;
        @(negedge clk);
        chk(tag, "trip evt_code", int'(evt_code), exp_code);
        chk(tag, "drive off after trip", int'(drive_en), 0);
        ocp_flag = 1'b0;
        prf_cur = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // r8_reset: all zero out of reset
        chk("R8", "reset drive_en", int'(drive_en), 0);
        chk("R8", "reset mis_cnt", int'(mis_cnt), 0);
        chk("R8", "reset ocp_cnt", int'(ocp_cnt), 0);
        chk("R8", "reset otp_cnt", int'(otp_cnt), 0);
        chk("R8", "reset reason", int'(mis_reason), 0);
        chk("R8", "reset locked", int'(locked), 0);
        chk("R8", "reset evt_valid", int'(evt_valid), 0);

        // R1: full proof with drive on, no mismatch
        cmd_on = 1; prf_cur = 1; prf_volt = 1;
        idle(1);
        chk("R1", "drive_en follows cmd", int'(drive_en), 1);
        tk(8);
        chk("R1", "agreement no mismatch", int'(mis_cnt), 0);

        // R2: voltage present but no current is not load proof
        prf_cur = 0;
        tk(2);
        chk("R2", "before persistence", int'(mis_cnt), 0);
        chk("R1", "obs_on voltage only", int'(obs_on), 1);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R2", "no-load evt_code", int'(evt_code), 1);
        chk("R2", "no-load mis_cnt", int'(mis_cnt), 1);
        chk("R2", "no-load reason", int'(mis_reason), 1);
        tk(5);
        chk("R4", "one event per episode", int'(mis_cnt), 1);

        // R3: off with current present
        cmd_on = 0; prf_cur = 1; prf_volt = 0;
        tk(2);
        chk("R4", "blanked after change", int'(mis_cnt), 1);
        tk(3);
        chk("R3", "stuck by current mis_cnt", int'(mis_cnt), 2);
        chk("R3", "stuck reason", int'(mis_reason), 2);
        prf_cur = 0;
        tk(1);
        prf_volt = 1;
        tk(3);
        chk("R3", "backfeed by voltage mis_cnt", int'(mis_cnt), 3);
        chk("R3", "backfeed reason", int'(mis_reason), 2);
        prf_volt = 0;

        // R4: late proof inside blanking, short dropouts, exact persistence
        cmd_on = 1; prf_cur = 0;
        tk(1);
        prf_cur = 1;
        tk(5);
        chk("R4", "late proof in settle", int'(mis_cnt), 3);
        chk("R8", "reason held", int'(mis_reason), 2);
        prf_cur = 0;
        tk(2);
        prf_cur = 1;
        tk(3);
        chk("R4", "two-tick dropout ignored", int'(mis_cnt), 3);
        prf_cur = 0;
        tk(3);
        chk("R4", "persist reached", int'(mis_cnt), 4);
        chk("R8", "reason updated", int'(mis_reason), 1);
        prf_cur = 1;
        tk(1);

        // R5 / R6: retry budget then lockout
        trip_pulse(2, "R5");
        chk("R5", "ocp_cnt first", int'(ocp_cnt), 1);
        tk(1);
        chk("R5", "still backing off", int'(drive_en), 0);
        tk(1);
        chk("R5", "retry restores drive", int'(drive_en), 1);
        prf_cur = 1;
        trip_pulse(2, "R5");
        tk(2);
        chk("R5", "second retry", int'(drive_en), 1);
        prf_cur = 1;
        trip_pulse(3, "R6");
        chk("R6", "locked set", int'(locked), 1);
        chk("R5", "ocp_cnt third", int'(ocp_cnt), 3);
        tk(5);
        chk("R6", "drive held off", int'(drive_en), 0);
        chk("R6", "no mismatch from trips", int'(mis_cnt), 4);
        @(negedge clk) lock_clr = 1'b1;
        @(negedge clk) lock_clr = 1'b0;
        chk("R6", "clear releases lock", int'(locked), 0);
        chk("R6", "drive after clear", int'(drive_en), 1);
        prf_cur = 1;

        // R7: overtemperature edge counted once
        idle(2);
        otp_flag = 1; prf_cur = 0;
        idle(2);
        chk("R7", "otp_cnt", int'(otp_cnt), 1);
        chk("R7", "otp drive off", int'(drive_en), 0);
        tk(4);
        chk("R7", "level not recounted", int'(otp_cnt), 1);
        chk("R7", "mis_cnt untouched", int'(mis_cnt), 4);
        otp_flag = 0; prf_cur = 1;
        idle(1);
        chk("R7", "drive back after otp", int'(drive_en), 1);

        // R9: otp edge and mismatch declaration on the same edge
        cmd_on = 0; prf_cur = 1;
        tk(2);
        tk(2);
        @(negedge clk) begin tick = 1'b1; otp_flag = 1'b1; end
        @(negedge clk);
        chk("R9", "priority code", int'(evt_code), 4);
        chk("R9", "mis counted", int'(mis_cnt), 5);
        chk("R9", "otp counted", int'(otp_cnt), 2);
        chk("R9", "reason", int'(mis_reason), 2);
        tick = 1'b0; otp_flag = 1'b0; prf_cur = 1'b0;
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule